// File: doc/BRIEF.md
# Configurable Memory Ordering Unit

This unit sits between the load/store issue stream of a single in-order core and a memory port. It collects requests into a small age-ordered queue and releases them to memory under one of three ordering disciplines chosen at run time. The strict discipline releases one operation at a time in program order. The intermediate discipline lets loads overtake older stores to other addresses but keeps stores in order. The relaxed discipline lets any operation overtake any older one that targets a different address. Two kinds of barrier entry, store-after-store and load-after-load, add ordering on request of software in any discipline.

Each memory request carries the queue slot number as its tag. Load data may come back in any order and is matched by that tag. The data is returned to the core strictly in program order, one result per cycle. A new discipline chosen on the mode input takes effect only once the queue is empty. An operation never overtakes an older unfinished operation to the same address, so a load always sees the value of the youngest older store.

Top module: `mo_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `req_ready` is 1, `mem_req_valid` and `ld_rsp_valid` are 0, and `cur_mode` is 0.
- R2: The queue holds DEPTH (8) entries of any kind, fences included. `req_ready` is 0 once DEPTH entries are held.
- R3: In mode 0 (strict; code 3 also behaves as mode 0), a load or store is presented to memory only when every older load and store has completed. A store completes when memory accepts it. A load completes when its response arrives.
- R4: In mode 1 (intermediate), a load is presented while older stores to other addresses are still incomplete, but it waits for all older loads. A store waits for every older load and store.
- R5: In mode 2 (relaxed), only an older incomplete operation to the same address holds a load or store back. Several loads may be outstanding at once.
- R6: In every mode, no load or store is presented while an older load or store to the same address is incomplete. Every load returns the value written by the youngest older store to its address, or 0 if there is none.
- R7: A fence with kind bit 0 holds every younger store until all stores older than the fence have completed.
- R8: A fence with kind bit 1 holds every younger load until all loads older than the fence have completed.
- R9: Among entries allowed to go in the same cycle, the oldest is presented first. At most one request is presented per cycle.
- R10: Load responses are accepted in any order and matched by `mem_rsp_id`. Load data reaches `ld_rsp_data` in program order.
- R11: `cur_mode` copies `mode_sel` only in a cycle that starts with the queue empty. Otherwise the previous mode is kept.
- R12: While `mem_req_valid` is high and `mem_req_ready` is low, the request and all of its fields are held unchanged.

Opcode field `req_op`: 0 load, 1 store, 2 fence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Requested ordering mode (0 strict, 1 intermediate, 2 relaxed) |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Queue can take a request |
| req_op | input | 2 | 0 load, 1 store, 2 fence |
| req_fkind | input | 1 | Fence kind: 0 store-store, 1 load-load |
| req_addr | input | AW | Operation address |
| req_data | input | DW | Store data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 store, 0 load |
| mem_req_addr | output | AW | Memory address |
| mem_req_data | output | DW | Store data to memory |
| mem_req_id | output | log2(DEPTH) | Request tag |
| mem_rsp_valid | input | 1 | Load response valid |
| mem_rsp_id | input | log2(DEPTH) | Tag of the answered load |
| mem_rsp_data | input | DW | Load data from memory |
| ld_rsp_valid | output | 1 | Load result to core valid |
| ld_rsp_data | output | DW | Load result to core |
| cur_mode | output | 2 | Ordering mode in force |

## Verification
The assertions assume that memory sends exactly one response for each accepted load. Each response carries the tag of a load that is still awaiting data, and at most one response arrives per cycle. The bench memory keeps a list of the tags it has accepted and not yet answered. It answers only from that list, picks a random member each time, and removes it when answering. The bench also keeps each core request steady until it is taken and never sends opcode 3.

// File: rtl/mo_pkg.sv
package mo_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FENCE = 2'd2
  } mo_op_e;

  typedef enum logic [1:0] {
    ORD_SEQ  = 2'd0,
    ORD_PROC = 2'd1,
    ORD_REL  = 2'd2
  } mo_mode_e;

  localparam logic FENCE_SS = 1'b0;
  localparam logic FENCE_LL = 1'b1;
endpackage

// File: rtl/mo_hazard.sv
module mo_hazard
  import mo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic [IW-1:0]              head,
  input  logic [DEPTH-1:0]           vld,
  input  logic [DEPTH-1:0]           iss,
  input  logic [DEPTH-1:0]           done,
  input  logic [DEPTH-1:0]           fkind,
  input  logic [DEPTH-1:0][1:0]      op,
  input  logic [DEPTH-1:0][AW-1:0]   addr,
  input  logic [1:0]                 mode,
  output logic [DEPTH-1:0]           elig,
  output logic [DEPTH-1:0]           fence_ok
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam logic [IW-1:0] MY = IW'(i);
    logic          blk;
    logic          fblk;
    logic [IW-1:0] age_i;
    logic [IW-1:0] age_j;
    logic          is_mem;

    always_comb begin
      blk   = 1'b0;
      fblk  = 1'b0;
      age_i = MY - head;
      age_j = '0;
      for (int j = 0; j < DEPTH; j++) begin
        age_j = IW'(j) - head;
        if (vld[j] && !done[j] && (age_j < age_i)) begin
          if (op[j] == OP_FENCE) begin
            if (fkind[j] == FENCE_SS && op[i] == OP_STORE) blk = 1'b1;
            if (fkind[j] == FENCE_LL && op[i] == OP_LOAD)  blk = 1'b1;
          end else begin
            if (addr[j] == addr[i]) blk = 1'b1;
            if (mode == ORD_PROC) begin
              if (op[i] == OP_STORE || op[j] == OP_LOAD) blk = 1'b1;
            end else if (mode != ORD_REL) begin
              blk = 1'b1;
            end
            if (op[i] == OP_FENCE) begin
              if (fkind[i] == FENCE_SS && op[j] == OP_STORE) fblk = 1'b1;
              if (fkind[i] == FENCE_LL && op[j] == OP_LOAD)  fblk = 1'b1;
            end
          end
        end
      end
    end

    assign is_mem      = (op[i] == OP_LOAD) || (op[i] == OP_STORE);
    assign elig[i]     = vld[i] && !iss[i] && is_mem && !blk;
    assign fence_ok[i] = vld[i] && (op[i] == OP_FENCE) && !done[i] && !fblk;
  end
endmodule

// File: rtl/mo_pick.sv
module mo_pick #(
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic [IW-1:0]    head,
  input  logic [DEPTH-1:0] elig,
  output logic             found,
  output logic [IW-1:0]    idx
);
  logic [IW-1:0] slot;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    slot  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = head + IW'(k);
      if (!found && elig[slot]) begin
        found = 1'b1;
        idx   = slot;
      end
    end
  end
endmodule

// File: rtl/mo_memreq.sv
module mo_memreq #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          we_in,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  input  logic [IW-1:0] id_in,
  input  logic          ready,
  output logic          free,
  output logic          valid,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data,
  output logic [IW-1:0] id
);
  assign free = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
    end else if (free) begin
      valid <= load;
    end
  end

  always_ff @(posedge clk) begin
    if (free && load) begin
      we   <= we_in;
      addr <= addr_in;
      data <= data_in;
      id   <= id_in;
    end
  end

  // R12
  hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(addr) && $stable(data) && $stable(id) && $stable(we)));
endmodule

// File: rtl/mo_unit.sv
module mo_unit
  import mo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode_sel,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic          req_fkind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_data,
  output logic [IW-1:0] mem_req_id,
  input  logic          mem_rsp_valid,
  input  logic [IW-1:0] mem_rsp_id,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          ld_rsp_valid,
  output logic [DW-1:0] ld_rsp_data,
  output logic [1:0]    cur_mode
);
  localparam int CW = IW + 1;

  // entry state
  logic [DEPTH-1:0]         e_vld, e_iss, e_done, e_fk;
  logic [DEPTH-1:0][1:0]    e_op;
  logic [DEPTH-1:0][AW-1:0] e_addr;
  logic [DW-1:0]            e_data [DEPTH];
  logic [DW-1:0]            e_rdat [DEPTH];
  logic [IW-1:0]            head, tail;
  logic [CW-1:0]            count;

  logic [DEPTH-1:0] elig, fence_ok;
  logic             pick_found, mr_free, issue, enq, retire, st_accept;
  logic [IW-1:0]    pick_idx;

  assign req_ready = (count < CW'(DEPTH));
  assign enq       = req_valid && req_ready;
  assign retire    = e_vld[head] && e_done[head];
  assign issue     = pick_found && mr_free;
  assign st_accept = mem_req_valid && mem_req_ready && mem_req_we;

  mo_hazard #(.DEPTH(DEPTH), .AW(AW)) u_haz (
    .head(head), .vld(e_vld), .iss(e_iss), .done(e_done), .fkind(e_fk),
    .op(e_op), .addr(e_addr), .mode(cur_mode), .elig(elig), .fence_ok(fence_ok)
  );

  mo_pick #(.DEPTH(DEPTH)) u_pick (
    .head(head), .elig(elig), .found(pick_found), .idx(pick_idx)
  );

  mo_memreq #(.AW(AW), .DW(DW), .IW(IW)) u_req (
    .clk(clk), .rst(rst), .load(issue),
    .we_in(e_op[pick_idx] == OP_STORE), .addr_in(e_addr[pick_idx]),
    .data_in(e_data[pick_idx]), .id_in(pick_idx), .ready(mem_req_ready),
    .free(mr_free), .valid(mem_req_valid), .we(mem_req_we),
    .addr(mem_req_addr), .data(mem_req_data), .id(mem_req_id)
  );

  // control state
  always_ff @(posedge clk) begin
    if (rst) begin
      e_vld        <= '0;
      e_iss        <= '0;
      e_done       <= '0;
      head         <= '0;
      tail         <= '0;
      count        <= '0;
      cur_mode     <= ORD_SEQ;
      ld_rsp_valid <= 1'b0;
    end else begin
      ld_rsp_valid <= 1'b0;
      if (count == '0) cur_mode <= mode_sel;
      if (enq) begin
        e_vld[tail]  <= 1'b1;
        e_iss[tail]  <= 1'b0;
        e_done[tail] <= 1'b0;
        e_op[tail]   <= req_op;
        e_fk[tail]   <= req_fkind;
        e_addr[tail] <= req_addr;
        tail         <= tail + 1'b1;
      end
      if (issue) e_iss[pick_idx] <= 1'b1;
      if (st_accept) e_done[mem_req_id] <= 1'b1;
      if (mem_rsp_valid) e_done[mem_rsp_id] <= 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        if (fence_ok[i]) e_done[i] <= 1'b1;
      end
      if (retire) begin
        e_vld[head] <= 1'b0;
        head        <= head + 1'b1;
        if (e_op[head] == OP_LOAD) begin
          ld_rsp_valid <= 1'b1;
          ld_rsp_data  <= e_rdat[head];
        end
      end
      count <= count + CW'(enq) - CW'(retire);
    end
  end

  // payload storage, no reset
  always_ff @(posedge clk) begin
    if (enq) e_data[tail] <= req_data;
  end

  always_ff @(posedge clk) begin
    if (mem_rsp_valid) e_rdat[mem_rsp_id] <= mem_rsp_data;
  end

  // R2
  count_limit_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (count != '0) |=> $stable(cur_mode));

  // R3
  seq_single_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_mode != ORD_PROC && cur_mode != ORD_REL) |-> ($countones(e_vld & e_iss & ~e_done) <= 1));

  // R10
  rsp_target_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid |-> (e_vld[mem_rsp_id] && e_iss[mem_rsp_id] && !e_done[mem_rsp_id]
                       && e_op[mem_rsp_id] == OP_LOAD));
endmodule

// File: tb/sim_mo_unit.sv
module sim_mo_unit;
  localparam int DEPTH  = 8;
  localparam int AW     = 8;
  localparam int DW     = 32;
  localparam int IW     = 3;
  localparam int MAXOPS = 4096;
  localparam int WDOG   = 150000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst;
  logic [1:0]    mode_sel;
  logic          req_valid, req_ready, req_fkind;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          mem_req_valid, mem_req_ready, mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_data;
  logic [IW-1:0] mem_req_id;
  logic          mem_rsp_valid;
  logic [IW-1:0] mem_rsp_id;
  logic [DW-1:0] mem_rsp_data;
  logic          ld_rsp_valid;
  logic [DW-1:0] ld_rsp_data;
  logic [1:0]    cur_mode;

  mo_unit #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .mode_sel(mode_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_fkind(req_fkind), .req_addr(req_addr), .req_data(req_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_data(mem_req_data), .mem_req_id(mem_req_id),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_id(mem_rsp_id),
    .mem_rsp_data(mem_rsp_data), .ld_rsp_valid(ld_rsp_valid),
    .ld_rsp_data(ld_rsp_data), .cur_mode(cur_mode)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit wd_hit = 0;

  // program-order model
  int            nops = 0, lo = 0;
  logic [1:0]    o_kind [MAXOPS];
  logic          o_fk   [MAXOPS];
  logic [AW-1:0] o_addr [MAXOPS];
  logic [DW-1:0] o_data [MAXOPS];
  bit            o_iss  [MAXOPS];
  bit            o_done [MAXOPS];
  logic [DW-1:0] ref_mem [256];
  logic [DW-1:0] bmem    [256];
  logic [DW-1:0] exp_q   [MAXOPS];
  int            exp_wr = 0, exp_rd = 0;
  int            outstanding = 0, snap = 0;

  // memory model
  int            pend_n = 0;
  logic [IW-1:0] pend_id  [16];
  logic [DW-1:0] pend_dat [16];
  int            id2seq   [DEPTH];
  int            issue_log [64];
  int            issue_n = 0;

  // driver state
  bit            cur_pend = 0, gen_on = 0, mem_stall = 0, rsp_stall = 0;
  int            gen_left = 0;
  logic [1:0]    c_op;
  logic          c_fk;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_data;
  logic [1:0]    prev_mode;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit strict_mode(logic [1:0] m);
    return (m != 2'd1) && (m != 2'd2);
  endfunction

  // ordering rules checked when op k is accepted by memory
  task automatic order_check(int k);
    bit    bad = 0;
    string r = "R6";
    int    who = -1;
    logic [1:0] m = cur_mode;
    for (int j = lo; j < k; j++) begin
      if (o_kind[j] == 2'd2) begin
        if ((o_fk[j] == 1'b0 && o_kind[k] == 2'd1) || (o_fk[j] == 1'b1 && o_kind[k] == 2'd0)) begin
          for (int i = lo; i < j; i++) begin
            if (o_kind[i] == o_kind[k] && !o_done[i] && !bad) begin
              bad = 1; who = i;
              r = o_fk[j] ? "R8 load fence" : "R7 store fence";
            end
          end
        end
      end else if (!o_done[j] && !bad) begin
        if (o_addr[j] == o_addr[k]) begin bad = 1; r = "R6 same address"; who = j; end
        else if (strict_mode(m)) begin bad = 1; r = "R3 strict"; who = j; end
        else if (m == 2'd1 && (o_kind[k] == 2'd1 || o_kind[j] == 2'd0)) begin
          bad = 1; r = "R4 intermediate"; who = j;
        end
      end
    end
    chk(!bad, r, "op issued ahead of incomplete older op (seq)", who, -1);
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (cyc > WDOG && !wd_hit) begin
      wd_hit = 1; checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WDOG);
    end
    if (!cur_pend && gen_on && gen_left > 0 && ($urandom % 3 != 0)) begin
      int r = $urandom % 100;
      c_op   = (r < 10) ? 2'd2 : ((r < 55) ? 2'd0 : 2'd1);
      c_fk   = 1'($urandom % 2);
      c_addr = AW'($urandom % 6);
      c_data = $urandom;
      cur_pend = 1;
      gen_left--;
    end
    if (gen_on && ($urandom % 300 == 0)) mode_sel = 2'($urandom % 3);
    req_valid = cur_pend; req_op = c_op; req_fkind = c_fk;
    req_addr = c_addr; req_data = c_data;
    mem_req_ready = mem_stall ? 1'b0 : ($urandom % 4 != 0);
    mem_rsp_valid = 1'b0;
    if (!rsp_stall && pend_n > 0 && ($urandom % 2 == 0)) begin
      int p = $urandom % pend_n;
      mem_rsp_valid = 1'b1;
      mem_rsp_id    = pend_id[p];
      mem_rsp_data  = pend_dat[p];
      pend_id[p]    = pend_id[pend_n-1];
      pend_dat[p]   = pend_dat[pend_n-1];
      pend_n--;
    end
    #1;
    // R11: mode may move only after the queue held nothing
    if (cur_mode !== prev_mode)
      chk(snap == 0, "R11", "mode changed with ops outstanding", snap, 0);
    prev_mode = cur_mode;
    // R10 R6: in-order load results with program-order values
    if (ld_rsp_valid) begin
      chk(exp_rd < exp_wr, "R10", "unexpected load result count", exp_rd, exp_wr);
      if (exp_rd < exp_wr) begin
        chk(ld_rsp_data == exp_q[exp_rd], "R6 R10", "load result data", ld_rsp_data, exp_q[exp_rd]);
        exp_rd++;
        outstanding--;
      end
    end
    snap = outstanding;
    if (mem_req_valid && mem_req_ready) begin
      int k = -1;
      for (int j = lo; j < nops; j++) begin
        if (k < 0 && !o_iss[j] && o_kind[j] == (mem_req_we ? 2'd1 : 2'd0) && o_addr[j] == mem_req_addr)
          k = j;
      end
      chk(k >= 0, "R6", "memory request matches a queued op", k, 0);
      if (k >= 0) begin
        order_check(k);
        o_iss[k] = 1;
        if (issue_n < 64) begin issue_log[issue_n] = k; issue_n++; end
        if (mem_req_we) begin
          chk(mem_req_data == o_data[k], "R6", "store data", mem_req_data, o_data[k]);
          bmem[mem_req_addr] = mem_req_data;
          o_done[k] = 1;
          outstanding--;
        end else begin
          pend_id[pend_n]  = mem_req_id;
          pend_dat[pend_n] = bmem[mem_req_addr];
          pend_n++;
          id2seq[mem_req_id] = k;
        end
      end
    end
    if (mem_rsp_valid) o_done[id2seq[mem_rsp_id]] = 1;
    if (req_valid && req_ready) begin
      o_kind[nops] = req_op; o_fk[nops] = req_fkind; o_addr[nops] = req_addr;
      o_data[nops] = req_data; o_iss[nops] = 0; o_done[nops] = (req_op == 2'd2);
      if (req_op == 2'd0) begin
        exp_q[exp_wr] = ref_mem[req_addr]; exp_wr++; outstanding++;
      end else if (req_op == 2'd1) begin
        ref_mem[req_addr] = req_data; outstanding++;
      end
      nops++;
      cur_pend = 0;
    end
    while (lo < nops && o_done[lo]) lo++;
  endtask

  task automatic push(logic [1:0] op, logic fk, logic [AW-1:0] a, logic [DW-1:0] d);
    c_op = op; c_fk = fk; c_addr = a; c_data = d; cur_pend = 1;
    while (cur_pend && !wd_hit) step();
  endtask

  task automatic drain();
    while (!wd_hit && (outstanding != 0 || pend_n != 0 || cur_pend)) step();
    repeat (5) step();
  endtask

  initial begin
    logic [AW-1:0] held;
    int base;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin ref_mem[i] = '0; bmem[i] = '0; end
    rst = 1'b1; mode_sel = 2'd2; req_valid = 0; req_op = 0; req_fkind = 0;
    req_addr = 0; req_data = 0; mem_req_ready = 0; mem_rsp_valid = 0;
    mem_rsp_id = 0; mem_rsp_data = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1 during reset
    chk(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid in reset", mem_req_valid, 0);
    chk(ld_rsp_valid == 1'b0, "R1", "ld_rsp_valid in reset", ld_rsp_valid, 0);
    chk(cur_mode == 2'd0, "R1", "cur_mode in reset", cur_mode, 0);
    prev_mode = cur_mode;
    rst = 1'b0;
    step();
    chk(mem_req_valid == 1'b0 && req_ready == 1'b1, "R1", "idle after reset", mem_req_valid, 0);

    // R11 adoption while empty
    repeat (3) step();
    chk(cur_mode == 2'd2, "R11", "mode adopted when empty", cur_mode, 2);

    // R2 R9 R12 R5: fill queue with memory stalled
    mem_stall = 1; rsp_stall = 1; issue_n = 0; base = nops;
    for (int i = 0; i < 7; i++) push(2'd0, 1'b0, AW'(16 + i), '0);
    push(2'd2, 1'b0, '0, '0);
    repeat (2) step();
    chk(req_ready == 1'b0, "R2", "req_ready when full", req_ready, 0);
    held = mem_req_addr;
    chk(mem_req_valid && held == AW'(16), "R9", "oldest load presented first", held, 16);
    repeat (3) step();
    chk(mem_req_valid && mem_req_addr == held, "R12", "request held while stalled", mem_req_addr, held);
    mode_sel = 2'd0;
    repeat (3) step();
    chk(cur_mode == 2'd2, "R11", "mode held while busy", cur_mode, 2);
    mem_stall = 0;
    for (int i = 0; i < 200 && issue_n < 7 && !wd_hit; i++) step();
    chk(issue_n == 7, "R5", "loads issued with no responses back", issue_n, 7);
    for (int i = 0; i < 7; i++)
      chk(issue_log[i] == base + i, "R9", "issue order", issue_log[i], base + i);
    rsp_stall = 0;
    drain();
    chk(cur_mode == 2'd0, "R11", "mode adopted after drain", cur_mode, 0);

    // directed same-address and fence cases in relaxed mode
    mode_sel = 2'd2; repeat (3) step();
    push(2'd1, 1'b0, AW'(40), 32'hA5A5_0001);
    push(2'd0, 1'b0, AW'(40), '0);
    push(2'd2, 1'b1, '0, '0);
    push(2'd0, 1'b0, AW'(41), '0);
    push(2'd1, 1'b0, AW'(42), 32'h0000_0042);
    push(2'd2, 1'b0, '0, '0);
    push(2'd1, 1'b0, AW'(43), 32'h0000_0043);
    drain();

    // random phases: R3 R4 R5 R6 R7 R8 R10
    for (int m = 0; m < 3 && !wd_hit; m++) begin
      mode_sel = 2'(m);
      repeat (3) step();
      gen_on = 1; gen_left = 400;
      while (!wd_hit && (gen_left > 0 || cur_pend)) step();
      gen_on = 0;
      drain();
    end
    chk(outstanding == 0 && exp_rd == exp_wr, "R10", "all loads answered", exp_rd, exp_wr);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule